// File: doc/BRIEF.md
# DMA Channel Pending and Busy Tracker

This block holds the per-channel bookkeeping that sits in front of a DMA arbiter. For every channel it keeps an enable bit, a suspend flag, a pending-status bit, a queue-membership bit and a busy bit. It takes in transfer triggers, enable and suspend/resume controls, a "descriptor promoted to active" event, and an end-of-burst outcome. From these it drives the request vector that the arbiter chooses from.

Pending status and queue membership are held apart. A suspended channel leaves the request vector, but software can still see that it had a request outstanding. When the channel is resumed it rejoins the queue. The busy bit follows the life of a request across several bursts. The first promotion sets it, and it stays set while bursts end with a re-queue. It drops when a burst ends by waiting for a new trigger, by suspending or by disabling.

Top module: `dma_chan_tracker`

## Requirements
- R1: A trigger on an enabled, not-suspended channel sets its pending bit and its request bit on the next cycle.
- R2: A trigger on a disabled or suspended channel changes nothing and is not remembered: resuming afterwards shows neither pending nor request.
- R3: Promoting a channel's descriptor to active clears its pending and request bits and sets its busy bit (busy stays 1 on later promotions of the same request).
- R4: End-of-burst outcome code 0 (re-queue) sets pending and request again and leaves busy at 1.
- R5: End-of-burst outcome code 1 (wait for trigger) clears busy and leaves the channel enabled, so a later trigger is accepted.
- R6: End-of-burst outcome code 2 (suspend) clears busy and sets the suspend flag.
- R7: End-of-burst outcome code 3 (disable) clears busy and disables the channel, so a later trigger is ignored.
- R8: Suspending a pending channel removes its request bit, keeps its pending bit at 1 and sets its suspend flag.
- R9: Resuming a suspended channel whose pending bit is still 1 restores its request bit and clears the suspend flag.
- R10: Disabling a channel clears its pending, request, busy and suspend bits.
- R11: When disable and trigger reach a channel in the same cycle, the disable takes effect and the trigger is dropped.
- R12: A request bit is 1 only when the channel is queued, enabled and not suspended. Several channels are tracked independently and can be pending at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | NCH | Per-channel transfer trigger pulse |
| en_set_i | input | NCH | Per-channel enable pulse |
| en_clr_i | input | NCH | Per-channel disable pulse |
| susp_i | input | NCH | Per-channel suspend pulse |
| resume_i | input | NCH | Per-channel resume pulse |
| promote_vld_i | input | 1 | A descriptor moves from prefetch to active |
| promote_ch_i | input | CHW | Channel of the promoted descriptor |
| done_vld_i | input | 1 | A burst has ended |
| done_ch_i | input | CHW | Channel whose burst ended |
| done_outcome_i | input | 2 | Outcome code: 0 re-queue, 1 wait, 2 suspend, 3 disable |
| req_o | output | NCH | Request vector to the arbiter |
| pend_o | output | NCH | Pending status per channel |
| busy_o | output | NCH | Busy status per channel |
| susp_o | output | NCH | Suspend flag per channel |

## Verification
The assertions assume that the controls are single-cycle pulses and that a promotion names a channel the arbiter could actually have granted, meaning one that is queued. They also assume that an end-of-burst outcome names only a channel that is busy. The stimulus keeps to this by promoting a channel only after its request bit has been observed and by closing a burst only after a promotion. The competing events that the design resolves by priority, such as disable together with trigger, are applied on purpose in the same cycle.

// File: rtl/dma_trk_pkg.sv
package dma_trk_pkg;
  typedef enum logic [1:0] {
    OUT_REQUEUE = 2'd0,
    OUT_WAIT    = 2'd1,
    OUT_SUSPEND = 2'd2,
    OUT_DISABLE = 2'd3
  } outcome_e;
endpackage

// File: rtl/dma_trk_decode.sv
module dma_trk_decode #(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           vld_i,
  input  logic [CHW-1:0] ch_i,
  output logic [NCH-1:0] hit_o
);
  for (genvar g = 0; g < NCH; g++) begin : g_dec
    assign hit_o[g] = vld_i && (ch_i == CHW'(g));
  end

  always_comb begin
    assert ($onehot0(hit_o)) else $error("assert_decode_onehot_R12");
  end
endmodule

// File: rtl/dma_trk_chan.sv
module dma_trk_chan
  import dma_trk_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     trig_i,
  input  logic     en_set_i,
  input  logic     en_clr_i,
  input  logic     susp_i,
  input  logic     resume_i,
  input  logic     promote_i,
  input  logic     done_i,
  input  outcome_e outcome_i,
  output logic     req_o,
  output logic     pend_o,
  output logic     busy_o,
  output logic     susp_o
);
  logic en_q, susp_q, pend_q, queued_q, busy_q;
  logic en_d, susp_d, pend_d, queued_d, busy_d;
  logic dis, live, acc_trig, requeue, susp_ev, res_ev, prom, idle_ev;

  // disable has top priority over every other event (R11)
  assign dis      = en_clr_i | (done_i & (outcome_i == OUT_DISABLE));
  assign live     = en_q & ~dis;
  assign acc_trig = trig_i & live & ~susp_q;
  assign requeue  = done_i & live & (outcome_i == OUT_REQUEUE);
  assign susp_ev  = live & (susp_i | (done_i & (outcome_i == OUT_SUSPEND)));
  assign res_ev   = live & resume_i & susp_q & ~susp_ev;
  assign prom     = promote_i & live;
  assign idle_ev  = done_i & ((outcome_i == OUT_WAIT) | (outcome_i == OUT_SUSPEND));

  always_comb begin
    en_d     = en_q;
    susp_d   = susp_q;
    pend_d   = pend_q;
    queued_d = queued_q;
    busy_d   = busy_q;
    if (dis) begin
      en_d     = 1'b0;
      susp_d   = 1'b0;
      pend_d   = 1'b0;
      queued_d = 1'b0;
      busy_d   = 1'b0;
    end else begin
      if (en_set_i) en_d = 1'b1;
      if (susp_ev)     susp_d = 1'b1;
      else if (res_ev) susp_d = 1'b0;
      if (acc_trig || requeue) pend_d = 1'b1;
      else if (prom)           pend_d = 1'b0;
      if (susp_ev)                  queued_d = 1'b0;
      else if (acc_trig || requeue) queued_d = 1'b1;
      else if (prom)                queued_d = 1'b0;
      else if (res_ev)              queued_d = pend_q;
      if (prom)         busy_d = 1'b1;
      else if (idle_ev) busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q     <= 1'b0;
      susp_q   <= 1'b0;
      pend_q   <= 1'b0;
      queued_q <= 1'b0;
      busy_q   <= 1'b0;
    end else begin
      en_q     <= en_d;
      susp_q   <= susp_d;
      pend_q   <= pend_d;
      queued_q <= queued_d;
      busy_q   <= busy_d;
    end
  end

  assign req_o  = queued_q & en_q & ~susp_q;
  assign pend_o = pend_q;
  assign busy_o = busy_q;
  assign susp_o = susp_q;

  assert_req_gated_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_o |-> (pend_q && en_q && !susp_q));
  assert_trig_accept_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && en_q && !susp_q && !en_clr_i && !done_i) |=> (pend_q && req_o));
  assert_trig_ignored_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trig_i && !en_q) |=> !pend_q);
  assert_promote_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (promote_i && en_q && !en_clr_i && !done_i && !trig_i) |=> (!pend_q && busy_q && !req_o));
  assert_requeue_busy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && outcome_i == OUT_REQUEUE && busy_q && en_q && !en_clr_i) |=> (busy_q && pend_q));
  assert_outcome_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && outcome_i != OUT_REQUEUE && !promote_i) |=> !busy_q);
  assert_susp_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (susp_i && en_q && pend_q && !en_clr_i && !done_i && !promote_i) |=> (pend_q && susp_q && !req_o));
  assert_disable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_clr_i |=> (!pend_q && !busy_q && !req_o && !susp_q));
endmodule

// File: rtl/dma_chan_tracker.sv
module dma_chan_tracker
  import dma_trk_pkg::*;
#(
  parameter int NCH = 4,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic [NCH-1:0] trig_i,
  input  logic [NCH-1:0] en_set_i,
  input  logic [NCH-1:0] en_clr_i,
  input  logic [NCH-1:0] susp_i,
  input  logic [NCH-1:0] resume_i,
  input  logic           promote_vld_i,
  input  logic [CHW-1:0] promote_ch_i,
  input  logic           done_vld_i,
  input  logic [CHW-1:0] done_ch_i,
  input  logic [1:0]     done_outcome_i,
  output logic [NCH-1:0] req_o,
  output logic [NCH-1:0] pend_o,
  output logic [NCH-1:0] busy_o,
  output logic [NCH-1:0] susp_o
);
  logic [NCH-1:0] prom_hit, done_hit;
  outcome_e       outcome;

  assign outcome = outcome_e'(done_outcome_i);

  dma_trk_decode #(.NCH(NCH)) u_dec_prom (
    .vld_i (promote_vld_i),
    .ch_i  (promote_ch_i),
    .hit_o (prom_hit)
  );

  dma_trk_decode #(.NCH(NCH)) u_dec_done (
    .vld_i (done_vld_i),
    .ch_i  (done_ch_i),
    .hit_o (done_hit)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    dma_trk_chan u_chan (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .trig_i    (trig_i[g]),
      .en_set_i  (en_set_i[g]),
      .en_clr_i  (en_clr_i[g]),
      .susp_i    (susp_i[g]),
      .resume_i  (resume_i[g]),
      .promote_i (prom_hit[g]),
      .done_i    (done_hit[g]),
      .outcome_i (outcome),
      .req_o     (req_o[g]),
      .pend_o    (pend_o[g]),
      .busy_o    (busy_o[g]),
      .susp_o    (susp_o[g])
    );
  end

  assert_req_subset_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((req_o & ~pend_o) == '0) && ((req_o & susp_o) == '0));
endmodule

// File: tb/dma_chan_tracker_test.sv
module dma_chan_tracker_test;
  localparam int NCH = 4;
  localparam int CHW = 2;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [NCH-1:0] trig, en_set, en_clr, susp, res;
  logic           prom_v, done_v;
  logic [CHW-1:0] prom_ch, done_ch;
  logic [1:0]     outc;
  logic [NCH-1:0] req, pend, busy, sflag;
  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  dma_chan_tracker #(.NCH(NCH)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .trig_i(trig), .en_set_i(en_set),
    .en_clr_i(en_clr), .susp_i(susp), .resume_i(res),
    .promote_vld_i(prom_v), .promote_ch_i(prom_ch),
    .done_vld_i(done_v), .done_ch_i(done_ch), .done_outcome_i(outc),
    .req_o(req), .pend_o(pend), .busy_o(busy), .susp_o(sflag)
  );

  task automatic clr_in();
    trig = '0; en_set = '0; en_clr = '0; susp = '0; res = '0;
    prom_v = 1'b0; prom_ch = '0; done_v = 1'b0; done_ch = '0; outc = '0;
  endtask

  task automatic step();
    @(negedge clk);
    clr_in();
  endtask

  task automatic chk(input string tag, input logic [NCH-1:0] act, input logic [NCH-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic promote(input int c);
    prom_v = 1'b1; prom_ch = CHW'(c); step();
  endtask

  task automatic finish_burst(input int c, input logic [1:0] code);
    done_v = 1'b1; done_ch = CHW'(c); outc = code; step();
  endtask

  initial begin
    clr_in();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R10 reset pend", pend, '0);
    chk("R10 reset req", req, '0);
    chk("R10 reset busy", busy, '0);
    chk("R10 reset susp", sflag, '0);

    for (int c = 0; c < NCH; c++) begin
      logic [NCH-1:0] m;
      m = NCH'(1) << c;
      trig = m; step();
      chk("R2 trig while disabled", pend, '0);
      en_set = m; step();
      trig = m; step();
      chk("R1 pend", pend, m);
      chk("R1 req", req, m);
      promote(c);
      chk("R3 pend cleared", pend, '0);
      chk("R3 req cleared", req, '0);
      chk("R3 busy set", busy, m);
      finish_burst(c, 2'd0);
      chk("R4 pend", pend, m);
      chk("R4 req", req, m);
      chk("R4 busy kept", busy, m);
      promote(c);
      chk("R3 busy stays", busy, m);
      finish_burst(c, 2'd1);
      chk("R5 busy cleared", busy, '0);
      chk("R5 pend", pend, '0);
      trig = m; step();
      chk("R5 still enabled", pend, m);
      susp = m; step();
      chk("R8 req dropped", req, '0);
      chk("R8 pend kept", pend, m);
      chk("R8 susp flag", sflag, m);
      trig = m; step();
      chk("R2 trig while suspended", req, '0);
      res = m; step();
      chk("R9 req back", req, m);
      chk("R9 susp cleared", sflag, '0);
      en_clr = m; step();
      chk("R10 pend cleared", pend, '0);
      chk("R10 req cleared", req, '0);
      en_set = m; step();
      trig = m; step();
      promote(c);
      finish_burst(c, 2'd2);
      chk("R6 susp set", sflag, m);
      chk("R6 busy cleared", busy, '0);
      trig = m; step();
      res = m; step();
      chk("R2 not remembered pend", pend, '0);
      chk("R2 not remembered req", req, '0);
      trig = m; step();
      promote(c);
      finish_burst(c, 2'd3);
      chk("R7 busy cleared", busy, '0);
      trig = m; step();
      chk("R7 disabled", pend, '0);
      en_set = m; step();
      en_clr = m; trig = m; step();
      chk("R11 pend", pend, '0);
      chk("R11 req", req, '0);
    end

    for (int mask = 1; mask < (1 << NCH); mask++) begin
      logic [NCH-1:0] mk, sm;
      mk = NCH'(mask);
      sm = mk & 4'b0101;
      en_set = '1; step();
      trig = mk; step();
      chk("R12 multi pend", pend, mk);
      chk("R12 multi req", req, mk);
      susp = sm; step();
      chk("R12 req masked by suspend", req, mk & ~sm);
      chk("R8 pend kept multi", pend, mk);
      res = sm; step();
      chk("R9 req restored multi", req, mk);
      en_clr = '1; step();
      chk("R10 all cleared", pend | req | busy | sflag, '0);
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule